// File: doc/BRIEF.md
# Radio Packet Transmit Framer

The block converts payload bytes held in a local transmit FIFO into a framed serial bitstream for a short-range radio modulator. Software loads only the payload. When a start pulse arrives, the block emits a header of its own: a configurable number of alternating-bit preamble bytes, a two-byte sync word and a length byte. It then sends the payload and ends the frame with a 16-bit CRC.

The modulator paces the output. One bit is consumed on each clock cycle in which the bit strobe is high, and `tx_bit` holds the current bit between strobes. When the last CRC bit has been consumed, the block pulses a packet-sent flag and returns to idle. A request for more payload bytes than the FIFO holds is refused: the block flags an underflow and sends nothing.

Top module: `pkt_tx_framer`

## Requirements
- R1: A frame carries, in this order: `pre_bytes` copies of 0xAA, then 0x2D, then 0xD4, then the length byte equal to `pay_len`, then the payload bytes in FIFO order, then the CRC high byte, then the CRC low byte. Each byte is sent most significant bit first.
- R2: While `tx_active` is high, `tx_bit` shows the bit currently being sent. The bit advances only after a cycle in which `bit_en` is high. `tx_bit` is 0 whenever `tx_active` is low.
- R3: The CRC uses polynomial 0x1021, seed 0xFFFF and no final inversion. It covers the length byte and the payload, processed most significant bit first.
- R4: With `pre_bytes` = 0, the frame begins directly with the sync word.
- R5: With `pay_len` = 0, no FIFO byte is sent and the CRC covers only the length byte.
- R6: A start pulse while idle raises `tx_active` on the next cycle. A start pulse while a frame is active, or in the packet-sent cycle, is ignored.
- R7: `pkt_sent` is high for exactly one cycle: the cycle after the strobe that consumes the last CRC bit. `tx_active` is low in that cycle.
- R8: If `pay_len` exceeds `fifo_level` when start is accepted, `underflow` is high for one cycle on the next cycle. No frame is sent and the FIFO is left unchanged.
- R9: The FIFO holds 64 bytes. A write while it is full is ignored. `fifo_level` reports the number of bytes stored.
- R10: A payload byte leaves the FIFO on the strobe that completes the byte before it. `fifo_level` drops on the following cycle.
- R11: After reset the block is idle: `tx_bit`, `tx_active`, `pkt_sent` and `underflow` are low and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Push `wr_data` into the payload FIFO |
| wr_data | input | 8 | Payload byte to store |
| fifo_level | output | 7 | Bytes currently stored |
| start | input | 1 | Request to send one frame |
| pre_bytes | input | 8 | Number of preamble bytes, sampled at start |
| pay_len | input | 8 | Payload length, sampled at start and sent as the length byte |
| bit_en | input | 1 | Strobe from the modulator: consume the current bit |
| tx_bit | output | 1 | Serial output bit |
| tx_active | output | 1 | A frame is being sent |
| pkt_sent | output | 1 | One-cycle pulse after the last bit |
| underflow | output | 1 | One-cycle pulse: start refused for lack of payload |

## Verification
A wrong sequencer state or byte counter shifts a header or payload byte boundary, and `tx_bit` diverges within eight strobes of the fault. A CRC register fault stays invisible until the trailing 16 bits, so every frame is compared bit for bit through its final CRC bit. FIFO pointer or count faults show up at once as a `fifo_level` mismatch, or as a wrong payload byte at the next byte boundary. Because the reference model is compared on every clock, a skipped or doubled strobe, or a `pkt_sent` pulse one cycle early or late, is reported in the cycle where it happens.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SYNC,
        ST_LEN,
        ST_PAY,
        ST_CRC,
        ST_DONE
    } tx_state_e;

    localparam logic [7:0]  PRE_PATTERN = 8'hAA;
    localparam logic [7:0]  SYNC_HI     = 8'h2D;
    localparam logic [7:0]  SYNC_LO     = 8'hD4;
    localparam logic [15:0] CRC_POLY    = 16'h1021;
    localparam logic [15:0] CRC_SEED    = 16'hFFFF;

endpackage

// File: rtl/pkt_tx_crc.sv
// One-bit serial step of a left-shifting CRC register.
module pkt_tx_crc #(
    parameter int          CRC_W = 16,
    parameter logic [15:0] POLY  = 16'h1021
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic             din,
    output logic [CRC_W-1:0] crc_out
);
    logic fb;

    always_comb begin
        fb      = crc_in[CRC_W-1] ^ din;
        crc_out = {crc_in[CRC_W-2:0], 1'b0} ^ (fb ? POLY[CRC_W-1:0] : '0);
    end
endmodule

// File: rtl/pkt_tx_fifo.sv
module pkt_tx_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [LW-1:0] level
);
    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [LW-1:0] count;
    } fifo_regs_t;

    fifo_regs_t r_q, r_d;
    logic [DW-1:0] mem [DEPTH];
    logic wr_ok;
    logic rd_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        r_d   = r_q;
        wr_ok = wr_en && (r_q.count != LW'(DEPTH));
        rd_ok = rd_en && (r_q.count != '0);
        if (wr_ok) r_d.wr_ptr = bump(r_q.wr_ptr);
        if (rd_ok) r_d.rd_ptr = bump(r_q.rd_ptr);
        case ({wr_ok, rd_ok})
            2'b10:   r_d.count = r_q.count + 1'b1;
            2'b01:   r_d.count = r_q.count - 1'b1;
            default: r_d.count = r_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[r_q.wr_ptr] <= wr_data;
    end

    assign rd_data = mem[r_q.rd_ptr];
    assign level   = r_q.count;

    // R9
    full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LW'(DEPTH) && wr_en && !rd_en) |=> (level == LW'(DEPTH)));

    // R9
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
endmodule

// File: rtl/pkt_tx_seq.sv
module pkt_tx_seq
    import pkt_tx_pkg::*;
#(
    parameter int DW    = 8,
    parameter int PRE_W = 8,
    parameter int LW    = 7,
    localparam int CNT_W = (PRE_W > DW) ? PRE_W : DW,
    localparam int CMP_W = ((DW > LW) ? DW : LW) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PRE_W-1:0] pre_bytes,
    input  logic [DW-1:0]    pay_len,
    input  logic             bit_en,
    input  logic [LW-1:0]    fifo_level,
    input  logic [DW-1:0]    fifo_head,
    output logic             fifo_pop,
    output logic             tx_bit,
    output logic             tx_active,
    output logic             pkt_sent,
    output logic             underflow
);
    typedef struct packed {
        tx_state_e        state;
        logic [7:0]       shreg;
        logic [2:0]       bit_cnt;
        logic [CNT_W-1:0] byte_cnt;
        logic [DW-1:0]    len;
        logic [15:0]      crc;
        logic             uflow;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    logic [15:0] crc_step;
    logic        bit_last;
    logic        short_fifo;

    pkt_tx_crc #(.CRC_W(16), .POLY(CRC_POLY)) u_crc (
        .crc_in (r_q.crc),
        .din    (r_q.shreg[7]),
        .crc_out(crc_step)
    );

    always_comb begin
        r_d        = r_q;
        r_d.uflow  = 1'b0;
        fifo_pop   = 1'b0;
        bit_last   = (r_q.bit_cnt == 3'd7);
        short_fifo = CMP_W'(pay_len) > CMP_W'(fifo_level);

        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.crc     = CRC_SEED;
                    r_d.len     = pay_len;
                    r_d.bit_cnt = '0;
                    if (short_fifo) begin
                        r_d.uflow = 1'b1;
                    end else if (pre_bytes != '0) begin
                        r_d.state    = ST_PRE;
                        r_d.shreg    = PRE_PATTERN;
                        r_d.byte_cnt = CNT_W'(pre_bytes) - 1'b1;
                    end else begin
                        r_d.state    = ST_SYNC;
                        r_d.shreg    = SYNC_HI;
                        r_d.byte_cnt = '0;
                    end
                end
            end
            ST_DONE: r_d.state = ST_IDLE;
            default: begin
                if (bit_en) begin
                    r_d.bit_cnt = r_q.bit_cnt + 1'b1;
                    r_d.shreg   = {r_q.shreg[6:0], 1'b0};
                    if (r_q.state == ST_LEN || r_q.state == ST_PAY)
                        r_d.crc = crc_step;
                    else if (r_q.state == ST_CRC)
                        r_d.crc = {r_q.crc[14:0], 1'b0};

                    if (bit_last) begin
                        case (r_q.state)
                            ST_PRE: begin
                                if (r_q.byte_cnt != '0) begin
                                    r_d.byte_cnt = r_q.byte_cnt - 1'b1;
                                    r_d.shreg    = PRE_PATTERN;
                                end else begin
                                    r_d.state    = ST_SYNC;
                                    r_d.shreg    = SYNC_HI;
                                end
                            end
                            ST_SYNC: begin
                                if (r_q.byte_cnt == '0) begin
                                    r_d.byte_cnt = CNT_W'(1);
                                    r_d.shreg    = SYNC_LO;
                                end else begin
                                    r_d.state    = ST_LEN;
                                    r_d.shreg    = r_q.len;
                                end
                            end
                            ST_LEN: begin
                                if (r_q.len != '0) begin
                                    r_d.state    = ST_PAY;
                                    r_d.shreg    = fifo_head;
                                    r_d.byte_cnt = CNT_W'(r_q.len) - 1'b1;
                                    fifo_pop     = 1'b1;
                                end else begin
                                    r_d.state    = ST_CRC;
                                    r_d.byte_cnt = CNT_W'(1);
                                end
                            end
                            ST_PAY: begin
                                if (r_q.byte_cnt != '0) begin
                                    r_d.shreg    = fifo_head;
                                    r_d.byte_cnt = r_q.byte_cnt - 1'b1;
                                    fifo_pop     = 1'b1;
                                end else begin
                                    r_d.state    = ST_CRC;
                                    r_d.byte_cnt = CNT_W'(1);
                                end
                            end
                            ST_CRC: begin
                                if (r_q.byte_cnt != '0)
                                    r_d.byte_cnt = r_q.byte_cnt - 1'b1;
                                else
                                    r_d.state = ST_DONE;
                            end
                            default: r_d.state = ST_IDLE;
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        tx_active = (r_q.state != ST_IDLE) && (r_q.state != ST_DONE);
        if (r_q.state == ST_CRC) tx_bit = r_q.crc[15];
        else if (tx_active)      tx_bit = r_q.shreg[7];
        else                     tx_bit = 1'b0;
        pkt_sent  = (r_q.state == ST_DONE);
        underflow = r_q.uflow;
    end

    // R7
    sent_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_sent |=> !pkt_sent);

    // R6
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && start) |=> (tx_active || pkt_sent));

    // R2
    hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !bit_en) |=> (tx_active && $stable(tx_bit)));

    // R8
    uflow_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> !tx_active);

    // R10
    pop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (bit_en && fifo_level != '0));

    // R2
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> !tx_bit);
endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer #(
    parameter int FIFO_DEPTH = 64,
    parameter int DW         = 8,
    parameter int PRE_W      = 8,
    localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    output logic [LW-1:0]    fifo_level,
    input  logic             start,
    input  logic [PRE_W-1:0] pre_bytes,
    input  logic [DW-1:0]    pay_len,
    input  logic             bit_en,
    output logic             tx_bit,
    output logic             tx_active,
    output logic             pkt_sent,
    output logic             underflow
);
    logic          pop;
    logic [DW-1:0] head;

    pkt_tx_fifo #(.DEPTH(FIFO_DEPTH), .DW(DW)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_en  (pop),
        .rd_data(head),
        .level  (fifo_level)
    );

    pkt_tx_seq #(.DW(DW), .PRE_W(PRE_W), .LW(LW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pre_bytes (pre_bytes),
        .pay_len   (pay_len),
        .bit_en    (bit_en),
        .fifo_level(fifo_level),
        .fifo_head (head),
        .fifo_pop  (pop),
        .tx_bit    (tx_bit),
        .tx_active (tx_active),
        .pkt_sent  (pkt_sent),
        .underflow (underflow)
    );
endmodule

// File: tb/pkt_tx_framer_tb.sv
module pkt_tx_framer_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [6:0] fifo_level;
    logic       start;
    logic [7:0] pre_bytes;
    logic [7:0] pay_len;
    logic       bit_en;
    logic       tx_bit, tx_active, pkt_sent, underflow;

    always #4 clk = ~clk;

    pkt_tx_framer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_level(fifo_level), .start(start), .pre_bytes(pre_bytes),
        .pay_len(pay_len), .bit_en(bit_en), .tx_bit(tx_bit),
        .tx_active(tx_active), .pkt_sent(pkt_sent), .underflow(underflow)
    );

    int    vectors = 0;
    int    errors  = 0;
    string cur_req = "R11";
    int    tick    = 0;

    bit         bitq[$];
    logic [7:0] fifoq[$];
    bit         m_busy = 0, m_sent = 0, m_uf = 0;
    int         consumed = 0, m_pre = 0, m_len = 0;

    function automatic logic [15:0] ref_crc(input logic [7:0] bytes[$]);
        logic [15:0] c = 16'hFFFF;
        foreach (bytes[i]) begin
            c = c ^ {bytes[i], 8'h00};
            for (int b = 0; b < 8; b++)
                c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    function automatic void push_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) bitq.push_back(v[i]);
    endfunction

    task automatic model_step(input bit st, input bit be, input bit we, input logic [7:0] wd);
        bit full;
        bit nsent;
        bit nuf;
        logic [7:0] cov[$];
        logic [15:0] c;
        full  = fifoq.size() >= 64;
        nsent = 0;
        nuf   = 0;
        if (m_sent) begin
        end else if (m_busy) begin
            if (be) begin
                void'(bitq.pop_front());
                consumed++;
                if (consumed % 8 == 0 && consumed / 8 >= m_pre + 3 &&
                    consumed / 8 < m_pre + 3 + m_len)
                    void'(fifoq.pop_front());
                if (bitq.size() == 0) begin
                    m_busy = 0;
                    nsent  = 1;
                end
            end
        end else if (st) begin
            if (int'(pay_len) > fifoq.size()) begin
                nuf = 1;
            end else begin
                bitq.delete();
                consumed = 0;
                m_pre = int'(pre_bytes);
                m_len = int'(pay_len);
                for (int p = 0; p < m_pre; p++) push_byte(8'hAA);
                push_byte(8'h2D);
                push_byte(8'hD4);
                push_byte(pay_len);
                cov.push_back(pay_len);
                for (int k = 0; k < m_len; k++) begin
                    push_byte(fifoq[k]);
                    cov.push_back(fifoq[k]);
                end
                c = ref_crc(cov);
                push_byte(c[15:8]);
                push_byte(c[7:0]);
                m_busy = 1;
            end
        end
        if (we && !full) fifoq.push_back(wd);
        m_sent = nsent;
        m_uf   = nuf;
    endtask

    task automatic chk1(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s) t=%0d: actual %0d expected %0d", tag, cur_req, tick, act, exp);
        end
    endtask

    task automatic compare();
        bit eb;
        eb = m_busy ? bitq[0] : 1'b0;
        chk1("R1 tx_bit",     int'(tx_bit),     int'(eb));
        chk1("R6 tx_active",  int'(tx_active),  int'(m_busy));
        chk1("R7 pkt_sent",   int'(pkt_sent),   int'(m_sent));
        chk1("R8 underflow",  int'(underflow),  int'(m_uf));
        chk1("R10 fifo_level", int'(fifo_level), fifoq.size());
    endtask

    task automatic cyc(input bit st, input bit be, input bit we, input logic [7:0] wd);
        start = st; bit_en = be; wr_en = we; wr_data = wd;
        model_step(st, be, we, wd);
        @(negedge clk);
        tick++;
        compare();
    endtask

    task automatic load(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) cyc(0, 0, 1, base + 8'(i));
    endtask

    task automatic run_frame(input int pre, input int len, input int mode,
                             input bit hold, input bit wr_during);
        int k;
        bit be;
        pre_bytes = 8'(pre);
        pay_len   = 8'(len);
        cyc(1, 0, 0, 8'h00);
        k = 0;
        while (m_busy || m_sent) begin
            case (mode)
                0:       be = 1'b1;
                1:       be = (k % 3 == 0);
                default: be = k[0];
            endcase
            cyc(hold, be, wr_during && (k % 5 == 0), 8'(k));
            k++;
        end
        cyc(0, 0, 0, 8'h00);
        cyc(0, 1, 0, 8'h00);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual still running, expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] digits[$];
        rst_n = 1'b0; wr_en = 0; wr_data = 0; start = 0; bit_en = 0;
        pre_bytes = 0; pay_len = 0;
        repeat (3) @(negedge clk);
        cur_req = "R11";
        compare();
        rst_n = 1'b1;
        cyc(0, 1, 0, 8'h00);

        // R3 check of the bench CRC against the standard check value
        for (int i = 0; i < 9; i++) digits.push_back(8'h31 + 8'(i));
        cur_req = "R3";
        chk1("R3 crc check value", int'(ref_crc(digits)), 32'h29B1);

        cur_req = "R1/R3";
        load(9, 8'h31);
        run_frame(3, 9, 0, 0, 0);

        cur_req = "R2/R6/R10";
        load(4, 8'h80);
        run_frame(1, 4, 1, 1, 1);

        cur_req = "R4";
        run_frame(0, 2, 2, 0, 0);

        cur_req = "R5";
        run_frame(2, 0, 0, 0, 0);

        cur_req = "R8";
        pre_bytes = 8'd1;
        pay_len   = 8'(fifoq.size() + 1);
        cyc(1, 1, 0, 8'h00);
        cyc(0, 1, 0, 8'h00);
        cyc(0, 1, 0, 8'h00);

        cur_req = "R9";
        load(70, 8'h10);
        run_frame(2, 64, 2, 0, 0);

        cur_req = "R7";
        load(3, 8'hC0);
        run_frame(1, 3, 0, 1, 0);

        summary();
        $finish;
    end
endmodule